// File: doc/BRIEF.md
# Serial-Clock Pulse-Pattern Reset Detector

This block watches a slow serial clock line and raises a reset request when the line carries a deliberate pattern of three long high pulses. Ordinary serial traffic never produces that pattern. The line is asynchronous to the system clock. It passes through a two-flop synchroniser, and every high and low interval is then measured in system clock cycles. A width is the number of rising `clk` edges at which the synchronised line holds that level.

The three high pulses must each fall inside their own width window, and each low gap between them must be long enough. When all conditions hold, a registered reset pulse one cycle wide is issued on the falling edge that ends the third pulse. A pulse that breaks the pattern sends the detector back to idle. If that same pulse fits the first window, it becomes the start of a new attempt. The output is a plain control pin with no handshake.

Top module: `pulse_pattern_reset`

## Requirements
- R1: While `rst_n` is low and just after it is released, `det_rst_o` is 0 and the detector is idle.
- R2: `line_in` passes two synchroniser flops. `det_rst_o` rises at the third rising `clk` edge at which `line_in` is already low after the third pulse, and is low at the two edges before.
- R3: The first pulse is accepted only when its width is strictly greater than 512 and strictly less than 800 cycles; widths of 512 or 800 are rejected.
- R4: A low gap between accepted pulses must be strictly greater than 10 cycles. A gap of 10 or fewer aborts the pattern to idle.
- R5: The second pulse is accepted only when its width is strictly between 1024 and 1800 cycles.
- R6: The third pulse completes the pattern when its width is at least 2048 and less than 2400 cycles, so 2048 and 2399 fire while 2047 and 2400 do not.
- R7: Each reset pulse on `det_rst_o` is exactly one `clk` cycle wide.
- R8: High pulses of 512 cycles or fewer, as in normal serial traffic, leave the detector idle and never cause a reset.
- R9: A second or third pulse outside its window aborts the attempt. If that pulse lies in the first window, it starts a new attempt; otherwise the detector goes idle.
- R10: Width counters saturate and do not wrap. A third pulse of 10392 cycles, which would alias to 2200 in a wrapping 13-bit counter, never fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that all widths are counted in |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw serial clock line, asynchronous to `clk` |
| det_rst_o | output | 1 | Registered reset request, one cycle high |

## Verification
Two events can land in the same cycle: the falling edge that fires the reset, and the first low cycle of the next gap, which the low counter starts measuring at once. The bench provokes this by running valid patterns back to back with gaps of only 11 to 15 cycles, and by letting random streams continue straight after a fire. After each completed pattern, the pulse that follows is judged against a reference sequence model that begins again from idle. A correct design fires again only when that model expects it.

// File: rtl/pulse_reset_pkg.sv
package pulse_reset_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GAP1 = 3'd1,
    ST_HI2  = 3'd2,
    ST_GAP2 = 3'd3,
    ST_HI3  = 3'd4
  } seq_state_t;

  function automatic int unsigned cnt_bits(input int unsigned max_w);
    return $clog2(max_w) + 1;
  endfunction
endpackage

// File: rtl/prr_sync.sv
module prr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic lvl_s,
  output logic lvl_d
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= async_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else lvl_d <= chain[STAGES-1];
  end

  assign lvl_s = chain[STAGES-1];
endmodule

// File: rtl/prr_width_meter.sv
module prr_width_meter #(
  parameter int unsigned CNT_W = 13,
  parameter bit          POL   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_s,
  input  logic             lvl_d,
  output logic [CNT_W-1:0] width_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic active, start;
  assign active = (lvl_s == POL);
  assign start  = active && (lvl_d != POL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) width_o <= '0;
    else if (start) width_o <= CNT_W'(1);
    else if (active && width_o != CNT_MAX) width_o <= width_o + 1'b1;
  end

  // R10: a saturated count holds while the level persists
  assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start && width_o == CNT_MAX) |=> (width_o == CNT_MAX));
endmodule

// File: rtl/prr_seq_fsm.sv
module prr_seq_fsm
  import pulse_reset_pkg::*;
#(
  parameter int unsigned CNT_W  = 13,
  parameter int unsigned W1_LO  = 512,
  parameter int unsigned W1_HI  = 800,
  parameter int unsigned GAP_LO = 10,
  parameter int unsigned W2_LO  = 1024,
  parameter int unsigned W2_HI  = 1800,
  parameter int unsigned W3_LO  = 2048,
  parameter int unsigned W3_HI  = 2400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic [CNT_W-1:0] hi_w,
  input  logic [CNT_W-1:0] lo_w,
  output logic             rst_o
);
  seq_state_t state, nxt;
  logic fire;
  logic in_w1, in_w2, in_w3, gap_ok;

  assign in_w1  = (hi_w > CNT_W'(W1_LO)) && (hi_w < CNT_W'(W1_HI));
  assign in_w2  = (hi_w > CNT_W'(W2_LO)) && (hi_w < CNT_W'(W2_HI));
  assign in_w3  = (hi_w >= CNT_W'(W3_LO)) && (hi_w < CNT_W'(W3_HI));
  assign gap_ok = (lo_w > CNT_W'(GAP_LO));

  always_comb begin
    nxt  = state;
    fire = 1'b0;
    unique case (state)
      ST_IDLE: if (fall) nxt = in_w1 ? ST_GAP1 : ST_IDLE;
      ST_GAP1: if (rise) nxt = gap_ok ? ST_HI2 : ST_IDLE;
      ST_HI2:  if (fall) nxt = in_w2 ? ST_GAP2 : (in_w1 ? ST_GAP1 : ST_IDLE);
      ST_GAP2: if (rise) nxt = gap_ok ? ST_HI3 : ST_IDLE;
      ST_HI3: if (fall) begin
        if (in_w3) begin
          fire = 1'b1;
          nxt  = ST_IDLE;
        end else begin
          nxt = in_w1 ? ST_GAP1 : ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rst_o <= 1'b0;
    end else begin
      state <= nxt;
      rst_o <= fire;
    end
  end

  // R7: never two consecutive reset cycles
  assert_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |=> !rst_o);

  // R6: a reset follows only a fall whose width was in the third window
  assert_fire_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> $past(fall && hi_w >= CNT_W'(W3_LO) && hi_w < CNT_W'(W3_HI)));

  // R4: a short gap after the first pulse aborts to idle
  assert_short_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP1 && rise && lo_w <= CNT_W'(GAP_LO)) |=> (state == ST_IDLE));

  // R1: idle state never fires on its own
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> !rst_o);
endmodule

// File: rtl/pulse_pattern_reset.sv
module pulse_pattern_reset
  import pulse_reset_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned W1_LO  = 512,
  parameter int unsigned W1_HI  = 800,
  parameter int unsigned GAP_LO = 10,
  parameter int unsigned W2_LO  = 1024,
  parameter int unsigned W2_HI  = 1800,
  parameter int unsigned W3_LO  = 2048,
  parameter int unsigned W3_HI  = 2400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic det_rst_o
);
  localparam int unsigned CNT_W = cnt_bits(W3_HI);

  logic lvl_s, lvl_d, rise, fall;
  logic [CNT_W-1:0] hi_w, lo_w;

  prr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(line_in), .lvl_s(lvl_s), .lvl_d(lvl_d)
  );

  assign rise = lvl_s && !lvl_d;
  assign fall = !lvl_s && lvl_d;

  prr_width_meter #(.CNT_W(CNT_W), .POL(1'b1)) u_hi (
    .clk(clk), .rst_n(rst_n), .lvl_s(lvl_s), .lvl_d(lvl_d), .width_o(hi_w)
  );

  prr_width_meter #(.CNT_W(CNT_W), .POL(1'b0)) u_lo (
    .clk(clk), .rst_n(rst_n), .lvl_s(lvl_s), .lvl_d(lvl_d), .width_o(lo_w)
  );

  prr_seq_fsm #(
    .CNT_W(CNT_W), .W1_LO(W1_LO), .W1_HI(W1_HI), .GAP_LO(GAP_LO),
    .W2_LO(W2_LO), .W2_HI(W2_HI), .W3_LO(W3_LO), .W3_HI(W3_HI)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .hi_w(hi_w), .lo_w(lo_w), .rst_o(det_rst_o)
  );

  // R2: a reset only appears while the synchronised line is low
  assert_fire_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    det_rst_o |-> !lvl_d);
endmodule

// File: tb/sim_pulse_pattern_reset.sv
module sim_pulse_pattern_reset;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b0;
  logic det_rst_o;

  int n_chk = 0;
  int n_bad = 0;
  int stage = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pulse_pattern_reset u0 (.clk(clk), .rst_n(rst_n), .line_in(line_in), .det_rst_o(det_rst_o));

  function automatic bit w1(int w); return w > 512 && w < 800; endfunction
  function automatic bit w2(int w); return w > 1024 && w < 1800; endfunction
  function automatic bit w3(int w); return w >= 2048 && w < 2400; endfunction

  // Reference sequence model from the requirements; returns 1 when a reset is due
  function automatic bit model_step(int gap, int w);
    bit f = 0;
    case (stage)
      1: stage = (gap > 10) ? (w2(w) ? 2 : (w1(w) ? 1 : 0)) : (w1(w) ? 1 : 0);
      2: if (gap > 10 && w3(w)) begin f = 1; stage = 0; end
         else stage = w1(w) ? 1 : 0;
      default: stage = w1(w) ? 1 : 0;
    endcase
    return f;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // gap: total low cycles before the rise (>=5); w: high cycles
  task automatic pulse(int gap, int w, string req);
    bit exp;
    logic [3:0] seen;
    @(negedge clk);
    line_in = 1'b0;
    repeat (gap - 5) @(negedge clk);
    line_in = 1'b1;
    repeat (w) @(negedge clk);
    line_in = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      seen[i] = det_rst_o;
    end
    exp = model_step(gap, w);
    check(seen == (exp ? 4'b0100 : 4'b0000), req, int'(seen), exp ? 4 : 0);
  endtask

  task automatic triple(int a, int g1, int b, int g2, int c, string req);
    pulse(20, a, req);
    pulse(g1, b, req);
    pulse(g2, c, req);
  endtask

  function automatic int rnd_w(int pos);
    int edges[12] = '{3, 40, 512, 513, 799, 800, 1024, 1800, 2047, 2048, 2399, 2400};
    if ($urandom % 10 < 7) begin
      case (pos)
        1: return 513 + int'($urandom % 286);
        2: return 1025 + int'($urandom % 774);
        default: return 2048 + int'($urandom % 352);
      endcase
    end
    return edges[$urandom % 12];
  endfunction

  function automatic int rnd_gap();
    if ($urandom % 10 < 8) return 11 + int'($urandom % 30);
    return 5 + int'($urandom % 6);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(det_rst_o == 1'b0, "R1 in reset", det_rst_o, 0);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check(det_rst_o == 1'b0, "R1 after release", det_rst_o, 0);

    triple(600, 20, 1500, 20, 2200, "R2 R3 R5 R6 R7 nominal");
    triple(512, 20, 1500, 20, 2200, "R3 low bound");
    triple(800, 20, 1500, 20, 2200, "R3 high bound");
    triple(513, 11, 1025, 11, 2048, "R3 R4 R5 R6 minimal");
    triple(799, 10, 1500, 20, 2200, "R4 gap of 10");
    triple(700, 20, 1500, 10, 2200, "R4 second gap of 10");
    triple(700, 20, 1024, 20, 2200, "R5 low bound");
    triple(700, 20, 1799, 20, 2399, "R5 R6 top edges");
    triple(700, 20, 1500, 20, 2047, "R6 below window");
    triple(700, 20, 1500, 20, 2400, "R6 above window");
    // R9: failing second pulse in first window restarts the attempt
    triple(600, 20, 700, 20, 1500, "R9 restart");
    pulse(20, 2200, "R9 completes");
    // R9: failing third pulse in first window restarts too
    triple(600, 15, 1500, 15, 650, "R9 third restart");
    pulse(15, 1300, "R9");
    pulse(15, 2100, "R9 fires");
    // R8: ordinary short traffic
    for (int k = 0; k < 40; k++) pulse(5 + int'($urandom % 8), 1 + int'($urandom % 512), "R8 short traffic");
    triple(650, 12, 1400, 12, 2300, "R8 then valid");
    // R10: very long third pulse must not alias into the window
    triple(600, 20, 1500, 20, 8192 + 2200, "R10 saturation");
    triple(600, 20, 1500, 20, 2200, "R10 recovery");
    // random streams
    for (int k = 0; k < 36; k++) begin
      int p = (k % 3) + 1;
      pulse(rnd_gap(), rnd_w(p), "R3 R4 R5 R6 R9 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule